// File: doc/BRIEF.md
# Sync Event Generation Controller

This block decides when a clock-distribution device raises its internal sync request. It watches an external sync pin, two PLL lock-detect flags and a strobe that pulses when the pulse-count register is written. An 8-bit control word shapes how these sources are combined. The block produces two outputs: a registered level that holds the divider outputs in sync, and a single-cycle trigger for a SYSREF pulser. The pulser itself is not part of the block.

The pin and both lock flags are asynchronous, so each passes through a two-flop synchronizer first. The pin polarity is then applied. Next comes either level tracking or a fixed-length one-shot. Lock-hold conditions are merged in after that. Finally the 2-bit mode routes the merged request to the sync output, to the pulser trigger, or to neither. In the mode that triggers on a register write, the strobe alone fires the pulser. The recommended reset value of the control word is 0x91: clear flag set, master enable set, direct mode.

Control word layout: bit 7 clear flag, bit 6 edge select, bit 5 invert, bit 4 enable, bit 3 hold-for-PLL2, bit 2 hold-for-PLL1, bits 1:0 mode.

Top module: `sync_event_ctrl`

## Requirements
- R1: While reset is held low, and on the first sample after it is released with an idle pin and disabled control, `sync_out` and `pulse_trig` are both 0.
- R2: With bit 5 = 0 the pin is active high. With bit 5 = 1 it is active low. The inversion is applied before any edge or level processing.
- R3: With bit 6 = 0 (level), bit 4 = 1 and mode 1, `sync_out` is high for exactly as many cycles as the active pin level lasts. The output lags the pin by three clock edges.
- R4: With bit 6 = 1 (edge), bit 4 = 1 and mode 1, each rising edge of the active request holds `sync_out` high for exactly SHOT_CYCLES cycles (default 8), whatever the width of the pin pulse.
- R5: With bit 4 = 0, neither output goes high, for any value of the other bits and any input activity.
- R6: With bit 3 = 1, `sync_out` stays high in mode 1 while the PLL2 lock flag is 0. Bit 2 does the same for the PLL1 lock flag.
- R7: Mode 0 (bits 1:0 = 00) keeps both outputs low, whatever the pin, lock and strobe activity.
- R8: Mode 1 (01) drives `sync_out` from the pin and lock-hold sources. It never pulses `pulse_trig`, even when the write strobe pulses.
- R9: Mode 2 (10) keeps `sync_out` low. It gives exactly one single-cycle `pulse_trig` for each rising edge of the merged pin and lock-hold request.
- R10: Mode 3 (11) keeps `sync_out` low and ignores the pin. It gives exactly one single-cycle `pulse_trig` for each rising edge of `pcnt_wr`.
- R11: While bit 7 = 1, `pulse_trig` stays low in every mode. `sync_out` is not affected.
- R12: Once the last held lock flag rises, `sync_out` falls on the third clock edge. That is two synchronizer stages plus the output register, with the output low on the cycle after the hold condition clears internally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pin | input | 1 | External sync request pin, asynchronous |
| pll1_lock | input | 1 | PLL1 lock-detect flag, asynchronous |
| pll2_lock | input | 1 | PLL2 lock-detect flag, asynchronous |
| ctrl_reg | input | 8 | Control word, layout given above |
| pcnt_wr | input | 1 | Strobe, high when the pulse-count register is written |
| sync_out | output | 1 | Registered sync level to the dividers |
| pulse_trig | output | 1 | Single-cycle trigger to the SYSREF pulser |

## Verification
The in-RTL assertions cover rules that hold on every cycle:
- the outputs stay quiet when the block is disabled or in mode 0;
- the clear flag suppresses the trigger;
- the sync level and the pulser trigger are never high together;
- the trigger never lasts two cycles under a stable control word;
- the one-shot counter stays within its bound;
- a pending lock holds the sync level.

Only the bench's scenarios can show the exact counts and latencies. These are the high-cycle count for level versus edge mode, one trigger per event in modes 2 and 3, the effect of inverting the pin, and the three-edge release after lock. The bench sweeps all 256 control words against one stimulus pattern.

// File: rtl/sync_evt_pkg.sv
package sync_evt_pkg;

  typedef enum logic [1:0] {
    MODE_BLOCK     = 2'd0,
    MODE_DIRECT    = 2'd1,
    MODE_PULSE_PIN = 2'd2,
    MODE_PULSE_WR  = 2'd3
  } sync_mode_e;

  // Packed MSB first: bit 7 down to bits 1:0
  typedef struct packed {
    logic       clr;
    logic       edge_sel;
    logic       invert;
    logic       enable;
    logic       hold_pll2;
    logic       hold_pll1;
    sync_mode_e mode;
  } sync_ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h91;

  function automatic logic apply_polarity(input logic raw, input logic inv);
    return raw ^ inv;
  endfunction

  function automatic logic lock_pending(input logic hold1, input logic hold2,
                                        input logic lock1, input logic lock2);
    return (hold1 & ~lock1) | (hold2 & ~lock2);
  endfunction

  function automatic logic rise(input logic now, input logic prev);
    return now & ~prev;
  endfunction

endpackage

// File: rtl/sync_evt_cdc.sv
module sync_evt_cdc #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sync_evt_shot.sv
module sync_evt_shot #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (fire)      cnt <= CNT_W'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  AST_SHOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CYCLES)); // R4

  AST_SHOT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> active); // R4

  AST_SHOT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !fire && active |=> cnt == $past(cnt) - 1'b1); // R4

endmodule

// File: rtl/sync_evt_route.sv
module sync_evt_route
  import sync_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       clr,
  input  sync_mode_e mode,
  input  logic       src_level,
  input  logic       wr_rise,
  output logic       sync_out,
  output logic       pulse_trig
);

  logic src_q;
  logic src_rise;
  logic sync_d;
  logic trig_d;

  assign src_rise = rise(src_level, src_q);
  assign sync_d   = enable && (mode == MODE_DIRECT) && src_level;
  assign trig_d   = enable && !clr &&
                    (((mode == MODE_PULSE_PIN) && src_rise) ||
                     ((mode == MODE_PULSE_WR)  && wr_rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= 1'b0;
      sync_out   <= 1'b0;
      pulse_trig <= 1'b0;
    end else begin
      src_q      <= src_level;
      sync_out   <= sync_d;
      pulse_trig <= trig_d;
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sync_out && !pulse_trig); // R5

  AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_BLOCK |=> !sync_out && !pulse_trig); // R7

  AST_CLR_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse_trig); // R11

  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_out && pulse_trig)); // R9

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_trig && mode == $past(mode) |=> !pulse_trig); // R10

endmodule

// File: rtl/sync_event_ctrl.sv
module sync_event_ctrl
  import sync_evt_pkg::*;
#(
  parameter int SHOT_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_pin,
  input  logic       pll1_lock,
  input  logic       pll2_lock,
  input  logic [7:0] ctrl_reg,
  input  logic       pcnt_wr,
  output logic       sync_out,
  output logic       pulse_trig
);

  sync_ctrl_t ctrl;
  logic [2:0] raw_in;
  logic [2:0] synced;
  logic       pin_s, lock1_s, lock2_s;
  logic       req, req_q, req_rise;
  logic       shot_active;
  logic       pin_act;
  logic       lock_wait;
  logic       src_level;
  logic       wr_q, wr_rise;

  assign ctrl   = sync_ctrl_t'(ctrl_reg);
  assign raw_in = {pll2_lock, pll1_lock, sync_pin};

  sync_evt_cdc #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_cdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_in),
    .sync_o   (synced)
  );

  assign pin_s   = synced[0];
  assign lock1_s = synced[1];
  assign lock2_s = synced[2];

  assign req      = apply_polarity(pin_s, ctrl.invert);
  assign req_rise = rise(req, req_q);
  assign wr_rise  = rise(pcnt_wr, wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      req_q <= req;
      wr_q  <= pcnt_wr;
    end
  end

  sync_evt_shot #(.CYCLES(SHOT_CYCLES)) u_shot (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (req_rise && ctrl.edge_sel),
    .active (shot_active)
  );

  assign pin_act   = ctrl.edge_sel ? shot_active : req;
  assign lock_wait = lock_pending(ctrl.hold_pll1, ctrl.hold_pll2, lock1_s, lock2_s);
  assign src_level = pin_act | lock_wait;

  sync_evt_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (ctrl.enable),
    .clr        (ctrl.clr),
    .mode       (ctrl.mode),
    .src_level  (src_level),
    .wr_rise    (wr_rise),
    .sync_out   (sync_out),
    .pulse_trig (pulse_trig)
  );

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.enable && ctrl.mode == MODE_DIRECT && lock_wait |=> sync_out); // R6

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.enable && ctrl.mode == MODE_DIRECT && !ctrl.edge_sel && req |=> sync_out); // R3

  AST_DIRECT_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mode == MODE_DIRECT |=> !pulse_trig); // R8

endmodule

// File: tb/tb_sync_event_ctrl.sv
`timescale 1ns/1ps
module tb_sync_event_ctrl;

  localparam int HOLD = 8;
  localparam int W    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_pin = 1'b0, pll1_lock = 1'b1, pll2_lock = 1'b1, pcnt_wr = 1'b0;
  logic [7:0] ctrl_reg = 8'h00;
  logic sync_out, pulse_trig;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_event_ctrl #(.SHOT_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .pll1_lock(pll1_lock),
    .pll2_lock(pll2_lock), .ctrl_reg(ctrl_reg), .pcnt_wr(pcnt_wr),
    .sync_out(sync_out), .pulse_trig(pulse_trig)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts output highs while a W-cycle active pin pulse and one strobe are applied
  task automatic window(input logic pol, output int nsync, output int ntrig);
    nsync = 0; ntrig = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      nsync += int'(sync_out);
      ntrig += int'(pulse_trig);
      sync_pin = (i < W) ? ~pol : pol;
      pcnt_wr  = (i == 0);
    end
    pcnt_wr = 1'b0;
  endtask

  initial begin
    int ns, nt, es, et;
    idle(3);
    check(sync_out == 1'b0 && pulse_trig == 1'b0, "R1 in reset", int'(sync_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sync_out == 1'b0 && pulse_trig == 1'b0, "R1 after release", int'(pulse_trig), 0);

    // Sweep every control word; locks high so bits 3/2 have no effect here
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cw;
      cw = 8'(c);
      ctrl_reg = cw;
      sync_pin = cw[5];
      idle(20);
      window(cw[5], ns, nt);
      es = 0; et = 0;
      if (cw[4] && cw[1:0] == 2'd1) es = cw[6] ? HOLD : W;   // R3 R4 R8
      if (cw[4] && cw[1:0] >= 2'd2 && !cw[7]) et = 1;       // R9 R10 R11
      // R5 and R7: disabled or mode 0 leave es = et = 0; R2: idle level = bit 5
      check(ns == es, $sformatf("R3/R4/R5/R7 sync cycles ctrl=%02h", cw), ns, es);
      check(nt == et, $sformatf("R9/R10/R11 trig count ctrl=%02h", cw), nt, et);
    end

    // R2: level direct mode, pin held low: idle for bit5=0, active for bit5=1
    sync_pin = 1'b0; ctrl_reg = 8'h11; idle(6);
    check(sync_out == 1'b0, "R2 pin low not inverted", int'(sync_out), 0);
    ctrl_reg = 8'h31; idle(6);
    check(sync_out == 1'b1, "R2 pin low inverted", int'(sync_out), 1);

    // R3 long level pulse vs R4 one-shot with long pulse
    ctrl_reg = 8'h11; sync_pin = 1'b0; idle(10);
    ns = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); ns += int'(sync_out); sync_pin = (i < 20);
    end
    check(ns == 20, "R3 level tracks 20 cycle pin", ns, 20);
    ctrl_reg = 8'h51; sync_pin = 1'b0; idle(20);
    ns = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); ns += int'(sync_out); sync_pin = (i < 20);
    end
    check(ns == HOLD, "R4 one-shot fixed length", ns, HOLD);

    // R3 latency: pin driven at a negedge, output high after the third edge
    ctrl_reg = 8'h11; sync_pin = 1'b0; idle(10);
    sync_pin = 1'b1;
    idle(2);
    check(sync_out == 1'b0, "R3 latency before third edge", int'(sync_out), 0);
    idle(1);
    check(sync_out == 1'b1, "R3 latency at third edge", int'(sync_out), 1);
    sync_pin = 1'b0; idle(6);

    // R6 and R12: hold for PLL2 (bit 3) then PLL1 (bit 2)
    pll2_lock = 1'b0; ctrl_reg = 8'h19; idle(6);
    check(sync_out == 1'b1, "R6 held while PLL2 unlocked", int'(sync_out), 1);
    pll2_lock = 1'b1; idle(2);
    check(sync_out == 1'b1, "R12 still high two edges after PLL2 lock", int'(sync_out), 1);
    idle(1);
    check(sync_out == 1'b0, "R12 low on third edge after PLL2 lock", int'(sync_out), 0);
    pll1_lock = 1'b0; ctrl_reg = 8'h15; idle(6);
    check(sync_out == 1'b1, "R6 held while PLL1 unlocked", int'(sync_out), 1);
    pll1_lock = 1'b1; idle(2);
    check(sync_out == 1'b1, "R12 still high two edges after PLL1 lock", int'(sync_out), 1);
    idle(1);
    check(sync_out == 1'b0, "R12 low on third edge after PLL1 lock", int'(sync_out), 0);

    // R6 with bit clear: unlocked flag ignored
    pll1_lock = 1'b0; ctrl_reg = 8'h11; idle(6);
    check(sync_out == 1'b0, "R6 unlocked PLL1 ignored without bit 2", int'(sync_out), 0);

    // R9: lock release fires pulser once in mode 2
    ctrl_reg = 8'h16; idle(6);
    pll1_lock = 1'b1; idle(6);
    pll1_lock = 1'b0; nt = 0; ns = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); nt += int'(pulse_trig); ns += int'(sync_out);
    end
    check(nt == 1 && ns == 0, "R9 lock-hold rising event one trigger", nt, 1);

    // R10: two separate strobes give two single-cycle triggers
    pll1_lock = 1'b1; ctrl_reg = 8'h13; idle(6);
    nt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); nt += int'(pulse_trig); pcnt_wr = (i == 2 || i == 3 || i == 10);
    end
    check(nt == 2, "R10 one trigger per strobe rising edge", nt, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule